// File: doc/BRIEF.md
# Hit Record Buffer with Double-Data-Rate Serial Readout

This block sits behind a 64-channel front end. It takes digitized hit records, each a channel number with an amplitude sample and an arrival-time sample, and keeps them in a four-entry first-in first-out store. A readout engine drains that store continuously. It sends each record as a fixed 28-bit word over two serial lanes. Every lane changes on both edges of the readout clock, so two lanes at 200 MHz give 800 Mbps in total.

Writes and reads are independent. In a single clock cycle a new record can enter while the oldest one leaves. The write side uses valid/ready. `in_ready` is high whenever the store has a free slot. The front end cannot stall, so it may present a record while `in_ready` is low. Such a record is discarded and a sticky overflow flag goes up. The flag stays up until software pulses the clear input. A frame strobe marks the first bit pair of every outgoing record. Receivers align on it.

Top module: `hitbuf_ddr_top`

## Requirements
- R1: The outgoing word is {channel[5:0], amplitude[9:0], time[9:0], 2'b00}, with bit 27 first. Lane 0 carries word bits 27..14 and lane 1 carries bits 13..0. Each lane sends its two most significant remaining bits per clock cycle: the higher bit while the clock is high, the lower bit while it is low.
- R2: The store holds four records. `in_ready` is high exactly when fewer than four are held. A record offered with `in_valid` high and `in_ready` high is stored on that clock edge.
- R3: `frame_out` is high for exactly the first clock cycle of each record, which lasts seven cycles. While records are waiting, the next one begins in the cycle right after the previous one ends.
- R4: Records leave in the order they were accepted, and none is lost or duplicated.
- R5: A record offered while `in_ready` is low is discarded, and `overflow` is high from the next clock edge.
- R6: `overflow` stays high until `ovf_clr` is sampled high. If a discard and a clear fall on the same edge, the flag stays set.
- R7: A write and a read on the same edge both take effect, and the number of stored records does not change.
- R8: While no record is being sent, both lanes are low and `frame_out` is low.
- R9: When the readout engine is idle, a record accepted on edge N starts (frame high, first bit pair) on edge N+1.
- R10: After reset, `in_ready` is high, and `overflow`, `frame_out` and both lanes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock; both edges carry data |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A hit record is presented |
| in_ready | output | 1 | A free slot exists; a record offered now is kept |
| in_chan | input | 6 | Channel number of the hit |
| in_amp | input | 10 | Amplitude sample |
| in_time | input | 10 | Arrival-time sample |
| ovf_clr | input | 1 | Clears the overflow flag |
| overflow | output | 1 | Sticky: a record was discarded |
| lane_out | output | 2 | Serial data lanes, both clock edges |
| frame_out | output | 1 | High during the first bit pair of a record |

## Verification
The assertions treat `in_valid` as a single-cycle offer with no obligation to hold. A discard is therefore a legitimate event, not a protocol breach, and the checks test only the flag behaviour that follows it. They also assume `ovf_clr` is a synchronous level sampled on the rising edge. The stimulus changes every input only just after a falling edge, far from the sampling edge. It deliberately drives offers into a full store and a clear on the same edge as a discard, so the corner cases in R5 and R6 both occur.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;
  localparam int CHAN_W = 6;
  localparam int AMP_W  = 10;
  localparam int TIME_W = 10;
  localparam int REC_W  = CHAN_W + AMP_W + TIME_W;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [AMP_W-1:0]  amp;
    logic [TIME_W-1:0] tstamp;
  } hit_rec_t;
endpackage

// File: rtl/hitbuf_fifo.sv
module hitbuf_fifo #(
  parameter int W     = 26,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_req,
  output logic [W-1:0]     rd_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_wr, do_rd;

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_req && !full;
  assign do_rd = rd_req && !empty;
  assign rd_data = mem[rptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/hitbuf_serializer.sv
module hitbuf_serializer #(
  parameter int LANES = 2,
  parameter int PAIRS = 7,
  localparam int SLICE_W = 2 * PAIRS,
  localparam int FRAME_W = SLICE_W * LANES,
  localparam int CNT_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_valid,
  input  logic [FRAME_W-1:0] src_word,
  output logic               src_pop,
  output logic [LANES-1:0]   rise_bits,
  output logic [LANES-1:0]   fall_bits,
  output logic               frame,
  output logic               busy
);
  logic [CNT_W-1:0] cnt;
  logic             last, load;

  assign last    = busy && (cnt == CNT_W'(PAIRS - 1));
  assign load    = src_valid && (!busy || last);
  assign src_pop = load;
  assign frame   = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (last) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SLICE_W-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sh <= '0;
      else if (load)
        sh <= src_word[FRAME_W-1-i*SLICE_W -: SLICE_W];
      else if (busy)
        sh <= {sh[SLICE_W-3:0], 2'b00};
    end
    assign rise_bits[i] = busy & sh[SLICE_W-1];
    assign fall_bits[i] = busy & sh[SLICE_W-2];
  end
endmodule

// File: rtl/hitbuf_ddr_mux.sv
module hitbuf_ddr_mux #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic [LANES-1:0] rise_bits,
  input  logic [LANES-1:0] fall_bits,
  output logic [LANES-1:0] lane_q
);
  for (genvar i = 0; i < LANES; i++) begin : g_mux
    always_comb lane_q[i] = clk ? rise_bits[i] : fall_bits[i];
  end
endmodule

// File: rtl/hitbuf_ddr_top.sv
module hitbuf_ddr_top
  import hitbuf_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 4,
  localparam int PAIRS   = (REC_W + 2 * LANES - 1) / (2 * LANES),
  localparam int FRAME_W = 2 * PAIRS * LANES,
  localparam int PAD_W   = FRAME_W - REC_W,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [AMP_W-1:0]  in_amp,
  input  logic [TIME_W-1:0] in_time,
  input  logic              ovf_clr,
  output logic              overflow,
  output logic [LANES-1:0]  lane_out,
  output logic              frame_out
);
  hit_rec_t           wr_rec, rd_rec;
  logic [LVL_W-1:0]   fifo_level;
  logic               fifo_full, fifo_empty, ser_pop, ser_busy, drop;
  logic [FRAME_W-1:0] ser_word;
  logic [LANES-1:0]   rise_bits, fall_bits;

  assign wr_rec   = '{chan: in_chan, amp: in_amp, tstamp: in_time};
  assign in_ready = !fifo_full;
  assign drop     = in_valid && fifo_full;
  assign ser_word = {rd_rec, {PAD_W{1'b0}}};

  hitbuf_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (in_valid),
    .wr_data (wr_rec),
    .rd_req  (ser_pop),
    .rd_data (rd_rec),
    .level   (fifo_level),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  hitbuf_serializer #(.LANES(LANES), .PAIRS(PAIRS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (!fifo_empty),
    .src_word  (ser_word),
    .src_pop   (ser_pop),
    .rise_bits (rise_bits),
    .fall_bits (fall_bits),
    .frame     (frame_out),
    .busy      (ser_busy)
  );

  hitbuf_ddr_mux #(.LANES(LANES)) u_mux (
    .clk       (clk),
    .rise_bits (rise_bits),
    .fall_bits (fall_bits),
    .lane_q    (lane_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overflow <= 1'b0;
    else if (drop)    overflow <= 1'b1;
    else if (ovf_clr) overflow <= 1'b0;
  end
endmodule

// File: rtl/hitbuf_ddr_checks.sv
module hitbuf_ddr_checks #(
  parameter int LANES = 2,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             ovf_clr,
  input logic             overflow,
  input logic             frame_out,
  input logic [LANES-1:0] rise_bits,
  input logic [LANES-1:0] fall_bits,
  input logic             ser_busy,
  input logic             ser_pop,
  input logic [LVL_W-1:0] fifo_level
);
  a_r2_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    ser_pop |-> fifo_level != '0);

  a_r7_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ser_pop) |=> fifo_level == $past(fifo_level));

  a_r5_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(in_valid && !in_ready)) |=> !overflow);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_busy |-> (rise_bits == '0 && fall_bits == '0 && !frame_out));

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_out |=> !frame_out);
endmodule

bind hitbuf_ddr_top hitbuf_ddr_checks #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .ovf_clr    (ovf_clr),
  .overflow   (overflow),
  .frame_out  (frame_out),
  .rise_bits  (rise_bits),
  .fall_bits  (fall_bits),
  .ser_busy   (ser_busy),
  .ser_pop    (ser_pop),
  .fifo_level (fifo_level)
);

// File: tb/sim_hitbuf_ddr_top.sv
module sim_hitbuf_ddr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [5:0] in_chan = '0;
  logic [9:0] in_amp = '0;
  logic [9:0] in_time = '0;
  logic       ovf_clr = 1'b0;
  logic       overflow;
  logic [1:0] lane_out;
  logic       frame_out;

  int checks = 0;
  int fails  = 0;
  logic [27:0] exp_q[$];

  always #5 clk = ~clk;

  hitbuf_ddr_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_amp(in_amp), .in_time(in_time),
    .ovf_clr(ovf_clr), .overflow(overflow), .lane_out(lane_out),
    .frame_out(frame_out)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: called just after a falling edge; offers one record for one cycle.
  task automatic send(input logic [5:0] c, input logic [9:0] a,
                      input logic [9:0] t, input bit exp_acc, input bit clr);
    in_valid = 1'b1; in_chan = c; in_amp = a; in_time = t; ovf_clr = clr;
    chk(in_ready == exp_acc, "R2 ready", 32'(in_ready), 32'(exp_acc));
    @(posedge clk); #1;
    if (exp_acc) exp_q.push_back({c, a, t, 2'b00});
    else chk(overflow == 1'b1, "R5 overflow after drop", 32'(overflow), 1);
    @(negedge clk); #1;
    in_valid = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Monitor / scoreboard
  initial begin
    logic [1:0]  r, fl;
    logic        fs;
    logic [27:0] w, e;
    bit          coll = 0;
    bit          need_frame = 0;
    int          idx = 0;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #2;
      r = lane_out; fs = frame_out;
      @(negedge clk); #2;
      fl = lane_out;
      if (need_frame) begin
        chk(fs == 1'b1, "R3 back-to-back frame", 32'(fs), 1);
        need_frame = 0;
      end
      if (fs) begin
        if (coll) chk(1'b0, "R3 frame inside record", 32'(idx), 7);
        coll = 1; idx = 0; w = '0;
      end
      if (coll) begin
        w[27-2*idx] = r[0];  w[26-2*idx] = fl[0];
        w[13-2*idx] = r[1];  w[12-2*idx] = fl[1];
        idx++;
        if (idx == 7) begin
          coll = 0;
          if (exp_q.size() == 0) chk(1'b0, "R4 unexpected record", 32'(w), 0);
          else begin
            e = exp_q.pop_front();
            chk(w == e, "R1 R4 record word", 32'(w), 32'(e));
            if (exp_q.size() > 0) need_frame = 1;
          end
        end
      end else begin
        chk(r == 2'b00 && fl == 2'b00, "R8 idle lanes", 32'({r, fl}), 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(in_ready == 1'b1, "R10 ready after reset", 32'(in_ready), 1);
    chk(overflow == 1'b0, "R10 overflow after reset", 32'(overflow), 0);
    chk(frame_out == 1'b0, "R10 frame after reset", 32'(frame_out), 0);
    chk(lane_out == 2'b00, "R10 lanes after reset", 32'(lane_out), 0);

    // R9 latency from idle
    send(6'h15, 10'h2AA, 10'h155, 1, 0);
    chk(frame_out == 1'b0, "R9 no frame on accept edge", 32'(frame_out), 0);
    @(posedge clk); #2;
    chk(frame_out == 1'b1, "R9 frame one edge later", 32'(frame_out), 1);
    idle(12);

    // Extreme values
    send(6'h3F, 10'h3FF, 10'h3FF, 1, 0);
    idle(9);
    send(6'h00, 10'h000, 10'h000, 1, 0);
    idle(9);

    // Burst: R2 capacity, R7 simultaneous write/read, R5, R6
    send(6'h01, 10'h101, 10'h011, 1, 0);
    send(6'h02, 10'h202, 10'h022, 1, 0);
    send(6'h03, 10'h303, 10'h033, 1, 0);
    send(6'h04, 10'h004, 10'h044, 1, 0);
    send(6'h05, 10'h105, 10'h055, 1, 0);
    send(6'h06, 10'h206, 10'h066, 0, 0);
    send(6'h07, 10'h307, 10'h077, 0, 1);
    chk(overflow == 1'b1, "R6 drop wins over clear", 32'(overflow), 1);
    idle(2);
    chk(overflow == 1'b1, "R6 flag sticky", 32'(overflow), 1);
    ovf_clr = 1'b1;
    idle(1);
    ovf_clr = 1'b0;
    chk(overflow == 1'b0, "R6 cleared", 32'(overflow), 0);
    idle(40);

    // Pseudo-random spaced records
    lf = 16'hACE1;
    for (int k = 0; k < 12; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[5:0], lf[15:6], {lf[9:0]} ^ 10'(k), 1, 0);
      idle(7 + (k % 3) * 2);
    end
    idle(60);
    chk(exp_q.size() == 0, "R4 all records delivered", 32'(exp_q.size()), 0);
    chk(overflow == 1'b0, "R6 no spurious overflow", 32'(overflow), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule